// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block runs the internal write cycles of a small serial flash. A serial front end decodes the chip-select frame and hands over byte-level events: the write command class, the 24-bit address once it has fully arrived, and each data byte after it. When chip select is released, the front end also reports whether the bit count ended exactly on a byte boundary. The sequencer fills a page buffer while program data streams in. If every condition for a write is met when the frame closes, it takes over and runs a self-timed cycle. That cycle is a page program, a single-sector erase, a whole-array erase or a status register update, and it drives a simple synchronous array port.

The cycle is timed in system clocks. A program cycle lasts a fixed number of clocks per byte, and erase and status writes each last their own fixed count per operation. Busy stays high for the whole cycle. A one-cycle completion pulse at its end tells the front end to clear its write-enable latch. Commands that arrive while busy is high are dropped, and so is any command that is incomplete, misaligned, not write-enabled or aimed at locked storage. Programming can only clear bits, because the array ANDs the written data into the stored byte. Erase returns bytes to 0xFF.

Top module: `flash_pe_sequencer`

## Requirements
- R1: After reset, busy and done are low, and none of the write strobes arr_we, arr_erase or sr_we is active.
- R2: A program frame writes each data byte to {page of the frame address, offset}. The offset starts at the address low byte and wraps from 0xFF to 0x00 inside the same page. Busy lasts PROG_CYC clocks per byte plus one completion cycle.
- R3: When more than 256 data bytes arrive, each page slot keeps only the most recent byte sent for it, and exactly 256 writes are issued.
- R4: No cycle starts, and no strobe or busy appears, in any of these cases: the frame ends with cs_aligned low; a program frame has no complete address or no data byte; or the target sector is locked.
- R5: If wen is low when the frame ends, the command is dropped and the sequencer stays idle.
- R6: A sector erase issues one arr_erase for the sector in address bits 17..16 and is busy for ERASE_CYC+1 clocks. It is dropped if that sector is locked.
- R7: A chip erase erases every unlocked sector in ascending order, ERASE_CYC clocks each. The lock level bp selects the locked sectors: 0 locks none, 1 the top quarter, 2 the top half, 3 all. With level 3 nothing starts.
- R8: A status write passes the first data byte after the opcode to sr_wdata with one sr_we and is busy for STAT_CYC+1 clocks. It is dropped while wp_lock is high.
- R9: done is a single-cycle pulse in the last busy cycle, with busy low in the next cycle, exactly once per executed command.
- R10: Command, address, data and frame-end events that arrive while busy are ignored and leave no pending command behind.
- R11: At most one write strobe is active in any cycle, and only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Write-class opcode received (new frame) |
| op_code | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 status write |
| addr_valid | input | 1 | Full address received |
| addr | input | ADDR_W | Byte address of the frame |
| data_valid | input | 1 | One data byte received |
| data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select released (frame end) |
| cs_aligned | input | 1 | Frame ended on a byte boundary |
| wen | input | 1 | Write-enable latch state |
| bp | input | 2 | Block lock level |
| wp_lock | input | 1 | Status register hardware-protected |
| busy | output | 1 | Internal cycle in progress |
| done | output | 1 | Cycle complete, clear write enable |
| arr_we | output | 1 | Program strobe for one byte |
| arr_addr | output | ADDR_W | Program byte address |
| arr_wdata | output | 8 | Program byte data |
| arr_erase | output | 1 | Sector erase strobe |
| arr_sector | output | SECT_W | Sector being erased |
| sr_we | output | 1 | Status register write strobe |
| sr_wdata | output | 8 | Status register write data |

## Verification
The bound checker watches, on every cycle, the strobe exclusivity and the rule that strobes appear only while busy. It also checks that busy can only rise right after a frame end, that busy falls only after a done pulse, and that no erase or program strobe ever touches a sector locked at the current level. Directed scenarios alone can show the byte-level outcome: page wrap, the choice of the last byte after an overflowing program, the sector order of a chip erase, the exact busy length, and the silent drops for misaligned, disabled, incomplete or protected frames.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [1:0] {
        OP_PROGRAM    = 2'd0,
        OP_SECT_ERASE = 2'd1,
        OP_CHIP_ERASE = 2'd2,
        OP_STAT_WRITE = 2'd3
    } fps_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_STAT,
        ST_DONE
    } fps_state_e;

    typedef struct packed {
        logic prog;
        logic erase;
        logic stat;
    } fps_strobe_t;

    // Locking always grows down from the top sector, so the unlocked
    // sectors are exactly 0 .. free_sectors-1.
    function automatic int unsigned free_sectors(input logic [1:0] level,
                                                 input int unsigned nsect);
        case (level)
            2'd0:    return nsect;
            2'd1:    return nsect - nsect / 4;
            2'd2:    return nsect / 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/flash_pe_lock.sv
module flash_pe_lock
    import flash_pe_pkg::*;
#(
    parameter int SECT_W = 2
) (
    input  logic [1:0]        level,
    input  logic [SECT_W-1:0] sect,
    output logic              locked,
    output logic [SECT_W:0]   n_free
);
    localparam int unsigned NSECT = 1 << SECT_W;

    assign n_free = (SECT_W + 1)'(free_sectors(level, NSECT));
    assign locked = ({1'b0, sect} >= n_free);
endmodule

// File: rtl/flash_pe_page_buf.sv
module flash_pe_page_buf #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_off,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_data,
    output logic [PAGE_W:0]   count
);
    localparam int PAGE = 1 << PAGE_W;
    localparam logic [PAGE_W:0] FULL = (PAGE_W + 1)'(PAGE);

    logic [7:0]        mem [PAGE];
    logic [PAGE_W-1:0] wptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            count <= '0;
        end else if (load) begin
            wptr  <= load_off;
            count <= '0;
        end else if (wr_en) begin
            wptr <= wptr + 1'b1;
            if (count != FULL) count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !load) mem[wptr] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int PAGE_W    = 8,
    parameter int SECT_W    = 2,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 40,
    parameter int STAT_CYC  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              data_valid,
    input  logic [7:0]        data,
    input  logic              cs_rise,
    input  logic              cs_aligned,
    input  logic              wen,
    input  logic [1:0]        bp,
    input  logic              wp_lock,
    output logic              busy,
    output logic              done,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              arr_erase,
    output logic [SECT_W-1:0] arr_sector,
    output logic              sr_we,
    output logic [7:0]        sr_wdata
);
    localparam int TMR_MAX = (PROG_CYC > ERASE_CYC) ?
                             ((PROG_CYC > STAT_CYC) ? PROG_CYC : STAT_CYC) :
                             ((ERASE_CYC > STAT_CYC) ? ERASE_CYC : STAT_CYC);
    localparam int TMR_W  = $clog2(TMR_MAX + 1);
    localparam int STEP_W = ((PAGE_W > SECT_W) ? PAGE_W : SECT_W) + 1;

    fps_state_e        state;
    fps_op_e           cur_op;
    logic              op_seen, addr_seen, sr_seen;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        sr_q;
    logic [TMR_W-1:0]  tmr, cyc_last;
    logic [STEP_W-1:0] step, last_step, nxt_last;
    logic [PAGE_W-1:0] run_off;
    logic [SECT_W-1:0] run_sect, tgt_sect;
    logic              tgt_locked, ok, launch, idle;
    logic [SECT_W:0]   n_free;
    logic [PAGE_W:0]   pb_count;
    logic [7:0]        pb_rdata;
    logic              pb_load, pb_wr;
    fps_state_e        nxt_state;
    fps_strobe_t       strb;

    assign idle     = (state == ST_IDLE);
    assign tgt_sect = addr_q[ADDR_W-1 -: SECT_W];

    flash_pe_lock #(.SECT_W(SECT_W)) u_lock (
        .level  (bp),
        .sect   (tgt_sect),
        .locked (tgt_locked),
        .n_free (n_free)
    );

    // Buffer capture only while collecting a program frame.
    assign pb_load = idle && !cs_rise && !op_valid && addr_valid && op_seen
                     && !addr_seen && (cur_op == OP_PROGRAM);
    assign pb_wr   = idle && !cs_rise && !op_valid && !addr_valid && data_valid
                     && op_seen && addr_seen && (cur_op == OP_PROGRAM);

    flash_pe_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk      (clk),
        .rst      (rst),
        .load     (pb_load),
        .load_off (addr[PAGE_W-1:0]),
        .wr_en    (pb_wr),
        .wr_data  (data),
        .rd_idx   (run_off),
        .rd_data  (pb_rdata),
        .count    (pb_count)
    );

    // Frame-end qualification per command class.
    always_comb begin
        ok        = 1'b0;
        nxt_state = ST_IDLE;
        nxt_last  = '0;
        unique case (cur_op)
            OP_PROGRAM: begin
                ok        = addr_seen && (pb_count != '0) && !tgt_locked;
                nxt_state = ST_PROG;
                nxt_last  = STEP_W'(pb_count) - STEP_W'(1);
            end
            OP_SECT_ERASE: begin
                ok        = addr_seen && !tgt_locked;
                nxt_state = ST_ERASE;
            end
            OP_CHIP_ERASE: begin
                ok        = (n_free != '0);
                nxt_state = ST_ERASE;
                nxt_last  = STEP_W'(n_free) - STEP_W'(1);
            end
            OP_STAT_WRITE: begin
                ok        = sr_seen && !wp_lock;
                nxt_state = ST_STAT;
            end
            default: ok = 1'b0;
        endcase
        launch = idle && cs_rise && cs_aligned && wen && op_seen && ok;
    end

    always_comb begin
        unique case (state)
            ST_PROG:  cyc_last = TMR_W'(PROG_CYC - 1);
            ST_ERASE: cyc_last = TMR_W'(ERASE_CYC - 1);
            ST_STAT:  cyc_last = TMR_W'(STAT_CYC - 1);
            default:  cyc_last = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_op    <= OP_PROGRAM;
            op_seen   <= 1'b0;
            addr_seen <= 1'b0;
            sr_seen   <= 1'b0;
            addr_q    <= '0;
            sr_q      <= '0;
            tmr       <= '0;
            step      <= '0;
            last_step <= '0;
            run_off   <= '0;
            run_sect  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cs_rise) begin
                        op_seen   <= 1'b0;
                        addr_seen <= 1'b0;
                        sr_seen   <= 1'b0;
                        if (launch) begin
                            state     <= nxt_state;
                            tmr       <= '0;
                            step      <= '0;
                            last_step <= nxt_last;
                            run_off   <= addr_q[PAGE_W-1:0];
                            run_sect  <= (cur_op == OP_CHIP_ERASE) ? '0 : tgt_sect;
                        end
                    end else if (op_valid) begin
                        cur_op    <= fps_op_e'(op_code);
                        op_seen   <= 1'b1;
                        addr_seen <= 1'b0;
                        sr_seen   <= 1'b0;
                    end else if (addr_valid && op_seen && !addr_seen) begin
                        addr_q    <= addr;
                        addr_seen <= 1'b1;
                    end else if (data_valid && op_seen && !sr_seen
                                 && (cur_op == OP_STAT_WRITE)) begin
                        sr_q    <= data;
                        sr_seen <= 1'b1;
                    end
                end
                ST_PROG, ST_ERASE, ST_STAT: begin
                    if (tmr == cyc_last) begin
                        tmr <= '0;
                        if (step == last_step) begin
                            state <= ST_DONE;
                        end else begin
                            step     <= step + 1'b1;
                            run_off  <= run_off + 1'b1;
                            run_sect <= run_sect + 1'b1;
                        end
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign strb.prog  = (state == ST_PROG)  && (tmr == '0);
    assign strb.erase = (state == ST_ERASE) && (tmr == '0);
    assign strb.stat  = (state == ST_STAT)  && (tmr == '0);

    assign busy       = !idle;
    assign done       = (state == ST_DONE);
    assign arr_we     = strb.prog;
    assign arr_addr   = {addr_q[ADDR_W-1:PAGE_W], run_off};
    assign arr_wdata  = pb_rdata;
    assign arr_erase  = strb.erase;
    assign arr_sector = run_sect;
    assign sr_we      = strb.stat;
    assign sr_wdata   = sr_q;
endmodule

// File: rtl/flash_pe_sequencer_chk.sv
module flash_pe_sequencer_chk
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SECT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_rise,
    input logic              busy,
    input logic              done,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              arr_erase,
    input logic [SECT_W-1:0] arr_sector,
    input logic              sr_we,
    input logic [1:0]        bp
);
    localparam int unsigned NSECT = 1 << SECT_W;

    assert_strobe_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (arr_we || arr_erase || sr_we) |-> (busy && !done));

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({arr_we, arr_erase, sr_we}));

    assert_start_on_frame_end_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_rise));

    assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_fall_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    assert_erase_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
        arr_erase |-> (int'(arr_sector) < int'(free_sectors(bp, NSECT))));

    assert_prog_unlocked_R4: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (int'(arr_addr[ADDR_W-1 -: SECT_W]) < int'(free_sectors(bp, NSECT))));
endmodule

bind flash_pe_sequencer flash_pe_sequencer_chk #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_rise    (cs_rise),
    .busy       (busy),
    .done       (done),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .arr_erase  (arr_erase),
    .arr_sector (arr_sector),
    .sr_we      (sr_we),
    .bp         (bp)
);

// File: tb/flash_pe_sequencer_tb.sv
`timescale 1ns/1ps
module flash_pe_sequencer_tb;
    localparam int PROG_CYC  = 4;
    localparam int ERASE_CYC = 40;
    localparam int STAT_CYC  = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 0, addr_valid = 0, data_valid = 0;
    logic [1:0]  op_code = 0;
    logic [17:0] addr = 0;
    logic [7:0]  data = 0;
    logic        cs_rise = 0, cs_aligned = 1, wen = 1, wp_lock = 0;
    logic [1:0]  bp = 0;
    logic        busy, done, arr_we, arr_erase, sr_we;
    logic [17:0] arr_addr;
    logic [7:0]  arr_wdata, sr_wdata;
    logic [1:0]  arr_sector;

    always #2 clk = ~clk;

    flash_pe_sequencer #(
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .STAT_CYC(STAT_CYC)
    ) u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .addr_valid(addr_valid), .addr(addr), .data_valid(data_valid), .data(data),
        .cs_rise(cs_rise), .cs_aligned(cs_aligned), .wen(wen), .bp(bp),
        .wp_lock(wp_lock), .busy(busy), .done(done), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_erase(arr_erase),
        .arr_sector(arr_sector), .sr_we(sr_we), .sr_wdata(sr_wdata)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // activity log, sampled away from the rising edge
    logic [17:0] wr_addr [512];
    logic [7:0]  wr_data [512];
    int          er_sec  [8];
    int n_wr, n_er, n_sr, busy_cnt, done_cnt, strobe_cnt;
    logic [7:0] sr_last;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            if (done) done_cnt++;
            if (arr_we || arr_erase || sr_we) strobe_cnt++;
            if (arr_we) begin
                if (n_wr < 512) begin
                    wr_addr[n_wr] = arr_addr;
                    wr_data[n_wr] = arr_wdata;
                end
                n_wr++;
            end
            if (arr_erase) begin
                if (n_er < 8) er_sec[n_er] = int'(arr_sector);
                n_er++;
            end
            if (sr_we) begin
                sr_last = sr_wdata;
                n_sr++;
            end
        end
    end

    task automatic clear_log();
        n_wr = 0; n_er = 0; n_sr = 0; busy_cnt = 0; done_cnt = 0; strobe_cnt = 0;
        sr_last = 8'h00;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_op(input logic [1:0] op);
        @(negedge clk); op_valid = 1; op_code = op;
        @(negedge clk); op_valid = 0;
    endtask

    task automatic send_addr(input logic [17:0] a);
        @(negedge clk); addr_valid = 1; addr = a;
        @(negedge clk); addr_valid = 0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk); data_valid = 1; data = d;
        @(negedge clk); data_valid = 0;
    endtask

    task automatic end_frame(input logic aligned);
        @(negedge clk);
        clear_log();
        cs_rise = 1; cs_aligned = aligned;
        @(negedge clk); cs_rise = 0; cs_aligned = 1;
    endtask

    task automatic settle();
        int guard = 0;
        @(negedge clk);
        while (busy && guard < 5000) begin @(negedge clk); guard++; end
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    task automatic t_reset();
        int seen = 0;
        repeat (4) begin
            @(negedge clk);
            if (busy || done || arr_we || arr_erase || sr_we) seen++;
        end
        chk("R1", "outputs active after reset", seen, 0);
    endtask

    task automatic t_program_basic();
        int bad = 0;
        send_op(2'd0); send_addr(18'h00510);
        send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
        end_frame(1); settle();
        chk("R2", "write count", n_wr, 3);
        for (int k = 0; k < 3; k++) begin
            if (wr_addr[k] != 18'h00510 + 18'(k)) bad++;
        end
        if (wr_data[0] != 8'hA1 || wr_data[1] != 8'hB2 || wr_data[2] != 8'hC3) bad++;
        chk("R2", "address/data mismatches", bad, 0);
        chk("R2", "busy cycles", busy_cnt, 3 * PROG_CYC + 1);
        chk("R9", "done pulses", done_cnt, 1);
    endtask

    task automatic t_program_wrap();
        int bad = 0;
        logic [17:0] exp_a [4] = '{18'h123FE, 18'h123FF, 18'h12300, 18'h12301};
        send_op(2'd0); send_addr(18'h123FE);
        for (int k = 0; k < 4; k++) send_byte(8'(16 + k));
        end_frame(1); settle();
        chk("R2", "wrap write count", n_wr, 4);
        for (int k = 0; k < 4; k++) begin
            if (wr_addr[k] != exp_a[k] || wr_data[k] != 8'(16 + k)) bad++;
        end
        chk("R2", "wrap mismatches", bad, 0);
    endtask

    task automatic t_program_overflow();
        int bad = 0;
        logic [7:0] e;
        send_op(2'd0); send_addr(18'h00200);
        for (int i = 0; i < 258; i++) send_byte(pat(i));
        end_frame(1); settle();
        chk("R3", "overflow write count", n_wr, 256);
        for (int j = 0; j < 256; j++) begin
            e = (j < 2) ? pat(256 + j) : pat(j);
            if (wr_addr[j] != (18'h00200 | 18'(j)) || wr_data[j] != e) bad++;
        end
        chk("R3", "overflow mismatches", bad, 0);
        chk("R3", "overflow busy cycles", busy_cnt, 256 * PROG_CYC + 1);
    endtask

    task automatic t_dropped();
        send_op(2'd0); send_addr(18'h00300); send_byte(8'h55);
        end_frame(0); settle();
        chk("R4", "misaligned frame busy", busy_cnt + strobe_cnt, 0);
        send_op(2'd0); send_addr(18'h00300);
        end_frame(1); settle();
        chk("R4", "program without data busy", busy_cnt + strobe_cnt, 0);
        send_op(2'd0); send_byte(8'h55);
        end_frame(1); settle();
        chk("R4", "program without address busy", busy_cnt + strobe_cnt, 0);
        bp = 2'd1;
        send_op(2'd0); send_addr(18'h30040); send_byte(8'h00);
        end_frame(1); settle();
        chk("R4", "program to locked sector busy", busy_cnt + strobe_cnt, 0);
        bp = 2'd0;
        wen = 0;
        send_op(2'd0); send_addr(18'h00300); send_byte(8'h55);
        end_frame(1); settle();
        chk("R5", "write-disabled busy", busy_cnt + strobe_cnt, 0);
        wen = 1;
    endtask

    task automatic t_sector_erase();
        send_op(2'd1); send_addr(18'h2ABCD);
        end_frame(1); settle();
        chk("R6", "erase strobes", n_er, 1);
        chk("R6", "erased sector", er_sec[0], 2);
        chk("R6", "erase busy cycles", busy_cnt, ERASE_CYC + 1);
        bp = 2'd2;
        send_op(2'd1); send_addr(18'h2ABCD);
        end_frame(1); settle();
        chk("R6", "locked sector erase busy", busy_cnt + strobe_cnt, 0);
        bp = 2'd0;
    endtask

    task automatic t_chip_erase();
        bp = 2'd1;
        send_op(2'd2);
        end_frame(1); settle();
        chk("R7", "chip erase sectors at level 1", n_er, 3);
        chk("R7", "order", er_sec[0] * 100 + er_sec[1] * 10 + er_sec[2], 12);
        chk("R7", "chip erase busy", busy_cnt, 3 * ERASE_CYC + 1);
        bp = 2'd3;
        send_op(2'd2);
        end_frame(1); settle();
        chk("R7", "full lock chip erase busy", busy_cnt + strobe_cnt, 0);
        bp = 2'd0;
    endtask

    task automatic t_status();
        send_op(2'd3); send_byte(8'h8C); send_byte(8'h11);
        end_frame(1); settle();
        chk("R8", "status strobes", n_sr, 1);
        chk("R8", "status data", int'(sr_last), 8'h8C);
        chk("R8", "status busy", busy_cnt, STAT_CYC + 1);
        wp_lock = 1;
        send_op(2'd3); send_byte(8'h80);
        end_frame(1); settle();
        chk("R8", "protected status busy", busy_cnt + strobe_cnt, 0);
        wp_lock = 0;
    endtask

    task automatic t_busy_ignore();
        send_op(2'd2);
        end_frame(1);
        repeat (5) @(negedge clk);
        send_op(2'd0); send_addr(18'h00040); send_byte(8'h12);
        @(negedge clk); cs_rise = 1;
        @(negedge clk); cs_rise = 0;
        settle();
        chk("R10", "erases during ignored frame", n_er, 4);
        chk("R10", "program writes leaked", n_wr, 0);
        chk("R10", "done pulses", done_cnt, 1);
        end_frame(1); settle();
        chk("R10", "stale command after busy", busy_cnt + strobe_cnt, 0);
    endtask

    initial begin
        clear_log();
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_program_basic();
        t_program_wrap();
        t_program_overflow();
        t_dropped();
        t_sector_erase();
        t_chip_erase();
        t_status();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule